// File: doc/BRIEF.md
# Periodic-Reference Trigger Synchronizer

This block lets a set of boards that run from a common, locked sample clock act on one shared trigger line in exactly the same sample clock cycle. Each board runs a free counter that produces a one-cycle Common Periodic Time Reference (CPTR) pulse every `period_i` sample clocks. The boards first bring their counters into phase. In self mode this happens on a rising edge of a reference clock that is sampled directly, with no synchronizer stages, so that every board sees the same edge. In host mode it happens on a strobe from the controlling host.

A rising edge on the trigger line is captured once it has passed a short synchronizer. It is held back and only appears on `trig_o` on the next CPTR pulse. Because every aligned board releases on the same pulse, the outputs coincide even though the raw edge reached each board at a different time. The block reports how many cycles the trigger was held. It flags a programmed period that is too short for the worst-case trigger propagation. It flags a reference edge that no longer matches the counter phase. It counts triggers that arrived before alignment.

Top module: `trig_align_sync`

## Requirements
- R1: The internal phase counter runs 0 to `period_i`-1 and wraps; `cptr_o` is high for exactly the one cycle in which the counter is 0, so pulses are `period_i` cycles apart. After reset the counter is 0.
- R2: In self mode (`mode_host_i`=0), while armed (after reset or a re-arm), the first cycle in which `ref_clk_i` is 1 and was 0 in the previous cycle restarts the counter. In the following cycle `cptr_o` and `aligned_o` are both 1.
- R3: In self mode, once aligned, each later reference rising edge must find the counter at `period_i`-1. Otherwise `phase_err_o` is set in the next cycle and stays set until the next alignment or re-arm.
- R4: In host mode (`mode_host_i`=1), a cycle with `host_align_i`=1 restarts the counter, so `cptr_o` and `aligned_o` are 1 in the next cycle. In self mode the same strobe re-arms the block and clears `aligned_o` in the next cycle.
- R5: A trigger rising edge is captured `SYNC_STAGES` cycles after the raw line rises. It appears on `trig_o` only in a cycle where `cptr_o` is high and strictly after the capture cycle, namely on the next CPTR pulse. A capture in a CPTR cycle therefore waits a full period.
- R6: `trig_o` is high for exactly one cycle per release. A further edge captured while one is pending merges into it and gives no extra pulse.
- R7: In the cycle after a release, `delay_o` holds the number of cycles from the first capture of the released trigger to the release cycle. This value lies between 1 and `period_i`.
- R8: An edge captured while `aligned_o` is 0, or in a cycle with an alignment or re-arm event, is dropped. It increments `drop_cnt_o`, which saturates at all ones.
- R9: `period_err_o` is 1 in the cycle after any cycle in which `period_i` is below `MIN_PERIOD`, and 0 after a cycle in which it is not.
- R10: An edge captured in the same cycle as a release starts a new pending trigger. That trigger is released on the following CPTR pulse with a delay of `period_i`.
- R11: An alignment or re-arm event discards any pending trigger, which is then never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock level, sampled without synchronizer |
| host_align_i | input | 1 | Host alignment strobe (host mode) / re-arm (self mode) |
| mode_host_i | input | 1 | 1 = host mode, 0 = self mode |
| period_i | input | CNT_W | CPTR period in sample clock cycles |
| trig_i | input | 1 | Raw shared trigger line |
| cptr_o | output | 1 | CPTR pulse |
| aligned_o | output | 1 | Counter phase has been aligned |
| trig_o | output | 1 | Synchronized trigger pulse |
| delay_o | output | CNT_W | Cycles between capture and release of the last trigger |
| phase_err_o | output | 1 | Reference edge found the counter out of phase |
| period_err_o | output | 1 | Programmed period below MIN_PERIOD |
| drop_cnt_o | output | DROP_W | Saturating count of dropped triggers |

## Verification
Two functions can share a cycle: a trigger capture and the release of the trigger that is already pending. A capture can also share a cycle with an alignment event. The bench places a second trigger edge so that its capture lands exactly on the CPTR cycle that releases the first. It then expects two separate pulses one period apart, with delays of the first wait and of a full period. It also issues a host alignment strobe while a trigger is pending, and the judgement is that no pulse appears at all in the next two periods.

// File: rtl/trig_sync_pkg.sv
`timescale 1ns/1ps
package trig_sync_pkg;
  typedef enum logic {
    MODE_SELF = 1'b0,
    MODE_HOST = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/cptr_gen.sv
`timescale 1ns/1ps
module cptr_gen
  import trig_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sync_mode_e       mode_i,
  input  logic             ref_clk_i,
  input  logic             host_align_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             cptr_o,
  output logic             aligned_o,
  output logic             phase_err_o,
  output logic             align_evt_o
);
  logic             ref_q;
  logic             ref_rise;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             armed_q, aligned_q, phase_err_q;
  logic             self_align, host_align, rearm;

  // reference level used raw: only one flop for edge detection
  assign ref_rise   = ref_clk_i & ~ref_q;
  assign last       = (period_i == '0) ? '0 : period_i - 1'b1;
  assign self_align = (mode_i == MODE_SELF) && armed_q && ref_rise;
  assign host_align = (mode_i == MODE_HOST) && host_align_i;
  assign rearm      = (mode_i == MODE_SELF) && host_align_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q       <= 1'b0;
      cnt_q       <= '0;
      armed_q     <= 1'b1;
      aligned_q   <= 1'b0;
      phase_err_q <= 1'b0;
    end else begin
      ref_q <= ref_clk_i;
      if (self_align || host_align || cnt_q >= last) cnt_q <= '0;
      else                                             cnt_q <= cnt_q + 1'b1;
      if (rearm) begin
        armed_q     <= 1'b1;
        aligned_q   <= 1'b0;
        phase_err_q <= 1'b0;
      end else if (self_align || host_align) begin
        armed_q     <= 1'b0;
        aligned_q   <= 1'b1;
        phase_err_q <= 1'b0;
      end else if ((mode_i == MODE_SELF) && aligned_q && ref_rise && (cnt_q != last)) begin
        phase_err_q <= 1'b1;
      end
    end
  end

  assign cptr_o      = (cnt_q == '0);
  assign aligned_o   = aligned_q;
  assign phase_err_o = phase_err_q;
  assign align_evt_o = self_align | host_align | rearm;
endmodule

// File: rtl/trig_capture.sv
`timescale 1ns/1ps
module trig_capture #(
  parameter int CNT_W       = 8,
  parameter int DROP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              cptr_i,
  input  logic              aligned_i,
  input  logic              align_evt_i,
  output logic              trig_o,
  output logic [CNT_W-1:0]  delay_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES:0]   chain;
  logic                   last_q, rise;
  logic                   pending_q;
  logic [CNT_W-1:0]       wait_q, wait_inc, delay_q;
  logic [DROP_W-1:0]      drop_q;
  logic                   release_now, capture_ok, drop_now;

  assign chain = {sync_q, trig_i};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= chain[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise        = sync_q[SYNC_STAGES-1] & ~last_q;
  assign release_now = pending_q & cptr_i & ~align_evt_i;
  assign capture_ok  = rise & aligned_i & ~align_evt_i;
  assign drop_now    = rise & ~capture_ok;
  assign wait_inc    = (wait_q == '1) ? wait_q : wait_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      wait_q    <= '0;
      delay_q   <= '0;
      drop_q    <= '0;
    end else begin
      if (align_evt_i) begin
        pending_q <= 1'b0;
        wait_q    <= '0;
      end else if (release_now) begin
        // capture in the release cycle starts a fresh wait
        pending_q <= capture_ok;
        wait_q    <= capture_ok ? CNT_W'(1) : '0;
      end else if (capture_ok && !pending_q) begin
        pending_q <= 1'b1;
        wait_q    <= CNT_W'(1);
      end else if (pending_q) begin
        wait_q    <= wait_inc;
      end
      if (release_now) delay_q <= wait_q;
      if (drop_now && drop_q != '1) drop_q <= drop_q + 1'b1;
    end
  end

  assign trig_o     = release_now;
  assign delay_o    = delay_q;
  assign drop_cnt_o = drop_q;
endmodule

// File: rtl/trig_align_sync.sv
`timescale 1ns/1ps
module trig_align_sync
  import trig_sync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int MIN_PERIOD  = 4,
  parameter int DROP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              host_align_i,
  input  logic              mode_host_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              trig_i,
  output logic              cptr_o,
  output logic              aligned_o,
  output logic              trig_o,
  output logic [CNT_W-1:0]  delay_o,
  output logic              phase_err_o,
  output logic              period_err_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam logic [CNT_W-1:0] MinPeriod = CNT_W'(MIN_PERIOD);

  sync_mode_e mode;
  logic       align_evt;
  logic       period_err_q;

  assign mode = sync_mode_e'(mode_host_i);

  cptr_gen #(.CNT_W(CNT_W)) u_cptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .ref_clk_i   (ref_clk_i),
    .host_align_i(host_align_i),
    .period_i    (period_i),
    .cptr_o      (cptr_o),
    .aligned_o   (aligned_o),
    .phase_err_o (phase_err_o),
    .align_evt_o (align_evt)
  );

  trig_capture #(
    .CNT_W      (CNT_W),
    .DROP_W     (DROP_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .cptr_i     (cptr_o),
    .aligned_i  (aligned_o),
    .align_evt_i(align_evt),
    .trig_o     (trig_o),
    .delay_o    (delay_o),
    .drop_cnt_o (drop_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) period_err_q <= 1'b0;
    else         period_err_q <= (period_i < MinPeriod);
  end

  assign period_err_o = period_err_q;
endmodule

// File: rtl/trig_align_sync_chk.sv
`timescale 1ns/1ps
module trig_align_sync_chk #(
  parameter int CNT_W      = 8,
  parameter int MIN_PERIOD = 4,
  parameter int DROP_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_align_i,
  input logic              mode_host_i,
  input logic [CNT_W-1:0]  period_i,
  input logic              cptr_o,
  input logic              aligned_o,
  input logic              trig_o,
  input logic [CNT_W-1:0]  delay_o,
  input logic              period_err_o,
  input logic [DROP_W-1:0] drop_cnt_o
);
  localparam logic [CNT_W-1:0] MinP = CNT_W'(MIN_PERIOD);

  p_host_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_align_i && mode_host_i |=> cptr_o && aligned_o);

  p_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_align_i && !mode_host_i |=> !aligned_o);

  p_release_on_cptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> cptr_o && aligned_o);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && period_i >= MinP |=> !trig_o);

  p_delay_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> delay_o != '0);

  p_drop_monotonic_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> drop_cnt_o >= $past(drop_cnt_o));

  p_period_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_i < MinP |=> period_err_o);
endmodule

bind trig_align_sync trig_align_sync_chk #(
  .CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD), .DROP_W(DROP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_align_i(host_align_i),
  .mode_host_i (mode_host_i),
  .period_i    (period_i),
  .cptr_o      (cptr_o),
  .aligned_o   (aligned_o),
  .trig_o      (trig_o),
  .delay_o     (delay_o),
  .period_err_o(period_err_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/trig_align_sync_bench.sv
`timescale 1ns/1ps
module trig_align_sync_bench;
  localparam int P  = 8;
  localparam int NS = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ref_clk = 1'b0, host_align = 1'b0, mode_host = 1'b1, trig = 1'b0;
  logic [7:0] period = 8'(P);
  logic       cptr, aligned, trig_o, phase_err, period_err;
  logic [7:0] delay;
  logic [2:0] drop;

  int n_chk = 0, n_bad = 0, ph = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_align_sync #(.CNT_W(8), .MIN_PERIOD(4), .DROP_W(3), .SYNC_STAGES(NS)) u_trig_align_sync (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .host_align_i(host_align),
    .mode_host_i(mode_host), .period_i(period), .trig_i(trig),
    .cptr_o(cptr), .aligned_o(aligned), .trig_o(trig_o), .delay_o(delay),
    .phase_err_o(phase_err), .period_err_o(period_err), .drop_cnt_o(drop)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ph = (ph + 1) % P;
  endtask

  task automatic host_align_now();
    mode_host = 1'b1; host_align = 1'b1;
    step();
    host_align = 1'b0; ph = 0;
    chk(cptr == 1'b1, "R4 cptr after strobe", cptr, 1);
    chk(aligned == 1'b1, "R4 aligned after strobe", aligned, 1);
  endtask

  task automatic goto_ph(input int target);
    while (ph != target) step();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(aligned == 1'b0, "R2 reset aligned", aligned, 0);
    chk(trig_o == 1'b0, "R6 reset trig", trig_o, 0);
    chk(drop == 3'd0, "R8 reset drop", drop, 0);
    chk(cptr == 1'b1, "R1 reset cptr", cptr, 1);
    chk(period_err == 1'b0, "R9 reset period_err", period_err, 0);
  endtask

  task automatic t_period_err();
    period = 8'd3;
    step();
    chk(period_err == 1'b1, "R9 short period", period_err, 1);
    period = 8'd4;
    step();
    chk(period_err == 1'b0, "R9 minimum period", period_err, 0);
    period = 8'(P);
    step();
  endtask

  task automatic t_drop();
    trig = 1'b1; step(); trig = 1'b0; step(); step();
    chk(drop == 3'd1, "R8 first drop", drop, 1);
    for (int e = 0; e < 8; e++) begin
      trig = 1'b1; step(); trig = 1'b0; step();
    end
    step(); step();
    chk(drop == 3'd7, "R8 saturated drop", drop, 7);
    chk(trig_o == 1'b0 && aligned == 1'b0, "R8 no release unaligned", trig_o, 0);
  endtask

  task automatic t_cptr_period();
    host_align_now();
    for (int i = 0; i < 2 * P; i++) begin
      chk(cptr == (ph == 0), "R1 cptr spacing", cptr, ph == 0);
      step();
    end
  endtask

  task automatic t_release(input int k, input string tag);
    int c, d;
    goto_ph(k);
    c = (k + NS) % P;
    d = (c == 0) ? P : P - c;
    trig = 1'b1;
    for (int i = 1; i <= NS + d + 1; i++) begin
      step();
      if (i == 1) trig = 1'b0;
      if (i <= NS + d) chk(trig_o == (i == NS + d), tag, trig_o, i == NS + d);
      else             chk(delay == 8'(d), "R7 delay", delay, d);
    end
  endtask

  task automatic t_merge();
    goto_ph(1);
    trig = 1'b1;
    for (int i = 1; i <= 15; i++) begin
      step();
      if (i == 1 || i == 3) trig = 1'b0;
      if (i == 2) trig = 1'b1;
      chk(trig_o == (i == 7), "R6 merged single pulse", trig_o, i == 7);
      if (i == 8) chk(delay == 8'd5, "R7 merged delay from first", delay, 5);
    end
  endtask

  task automatic t_same_cycle();
    goto_ph(1);
    trig = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      step();
      if (i == 1 || i == 6) trig = 1'b0;
      if (i == 5) trig = 1'b1;
      if (i <= 15) chk(trig_o == (i == 7 || i == 15), "R10 capture at release", trig_o, i == 7 || i == 15);
      if (i == 8) chk(delay == 8'd5, "R10 first delay", delay, 5);
      if (i == 16) chk(delay == 8'(P), "R10 full period delay", delay, P);
    end
  endtask

  task automatic t_align_clears();
    goto_ph(1);
    trig = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (i == 1) trig = 1'b0;
      if (i == 3) host_align = 1'b1;
      if (i == 4) begin host_align = 1'b0; ph = 0; end
      chk(trig_o == 1'b0, "R11 pending discarded", trig_o, 0);
    end
    chk(aligned == 1'b1, "R11 still aligned", aligned, 1);
  endtask

  task automatic t_self();
    mode_host = 1'b0; host_align = 1'b1;
    step();
    host_align = 1'b0;
    chk(aligned == 1'b0, "R4 self re-arm", aligned, 0);
    step(); step(); step();
    chk(aligned == 1'b0, "R2 waits for ref edge", aligned, 0);
    ref_clk = 1'b1;
    step(); ph = 0;
    chk(cptr == 1'b1 && aligned == 1'b1, "R2 aligned on ref edge", {cptr, aligned}, 3);
    for (int i = 2; i <= 32; i++) begin
      step();
      if (i == 8 || i == 24) ref_clk = 1'b0;
      if (i == 16 || i == 31) ref_clk = 1'b1;
      if (i == 17) chk(phase_err == 1'b0 && cptr == 1'b1, "R3 edge in phase", phase_err, 0);
      if (i == 31) chk(phase_err == 1'b0, "R3 no flag before edge", phase_err, 0);
      if (i == 32) chk(phase_err == 1'b1 && aligned == 1'b1, "R3 edge out of phase", phase_err, 1);
    end
  endtask

  initial begin
    t_reset();
    t_period_err();
    t_drop();
    t_cptr_period();
    t_release(0, "R5 capture mid period");
    t_release(5, "R5 capture just before cptr");
    t_release(6, "R5 capture on cptr waits full period");
    t_merge();
    t_same_cycle();
    t_align_clears();
    t_self();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule